// File: doc/BRIEF.md
# Serial Frequency Word Transmitter

This block takes the carrier frequency-offset word that a loop filter produces and sends it bit by bit to a downstream tuner, numerically controlled oscillator or digital-to-analog converter. A one-cycle load strobe presents a 32-bit word. The block then drives a serial data line, a serial clock and a frame signal that marks the bits of one word.

The word length can be cut to 8, 16, 24 or 32 bits. The upper bits are kept and the most significant bit goes first. A short word ends sooner, so the loop sees less delay and can update faster. The serial clock runs either at the master rate (one bit per master cycle) or at the master rate divided by 2, 4, 8 or 16. The length, divide ratio and clock select are captured when a word starts. One load that arrives while the block is busy is held and sent after a single idle cycle.

Top module: `freq_serial_tx`

## Requirements
- R1: After reset, serFrame, busy, serClk and serData are all low.
- R2: A load strobe sampled high while busy is low starts a word on that edge. From the next cycle, serFrame is high for exactly L×P master cycles, where L is the bit count and P the bit period.
- R3: lenCode 0, 1, 2 and 3 give L = 8, 16, 24 and 32. The bits sent are wordIn[31] down to wordIn[32−L], most significant first.
- R4: With slowSel = 0, each bit lasts one master cycle (P = 1).
- R5: With slowSel = 1, each bit lasts P = 2 << divCode master cycles, so divCode 0, 1, 2 and 3 give 2, 4, 8 and 16.
- R6: With slowSel = 1, serClk is low for the first P/2 cycles of each bit and high for the last P/2. serData changes only while serClk is low, and serClk is low while serFrame is low.
- R7: busy is high while serFrame is high and while a word is held. A load taken while busy is held. Its word starts after serFrame has been low for exactly one cycle, and busy stays high through that gap.
- R8: A load that arrives while a word is already held is dropped. No extra frame follows.
- R9: lenCode, divCode and slowSel are sampled when a word starts. Changes during its frame do not affect that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low asynchronous reset |
| loadStb | input | 1 | One-cycle strobe that offers wordIn |
| wordIn | input | 32 | Frequency-offset word |
| lenCode | input | 2 | Word length select (8/16/24/32 bits) |
| divCode | input | 2 | Slow clock ratio select (2/4/8/16) |
| slowSel | input | 1 | 0 = master-rate bits, 1 = divided serial clock |
| serData | output | 1 | Serial data, MSB first |
| serClk | output | 1 | Serial clock; receiver samples on its rising edge |
| serFrame | output | 1 | High while the bits of a word are driven |
| busy | output | 1 | High while a word is sent or held |

## Verification
On every cycle the assertions check four things:
- busy covers the frame, and a load taken while busy keeps busy high.
- A load into an idle block raises the frame on the next cycle, and no frame exceeds the longest word at the slowest clock.
- In divided mode, data holds steady while the serial clock is high.
- The serial clock stays low outside a frame.

Only the bench scenarios can show the rest:
- the exact bit order for each word length;
- the exact frame length for each clock ratio;
- the one-cycle gap before a held word;
- that a third load is dropped;
- that configuration changes during a frame are ignored.

// File: rtl/ftx_pkg.sv
package ftx_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic launchNew;   // load wordIn into the shifter
    logic launchHeld;  // load the held word into the shifter
    logic captureHold; // store wordIn in the hold register
    logic shiftNext;   // advance to the next bit
  } ftxStrobe_t;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SHIFT = 1'b1
  } ftxState_t;

endpackage

// File: rtl/ftx_ctrl.sv
module ftx_ctrl
  import ftx_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int LEN_CODE_W = 2,
  parameter int DIV_CODE_W = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  loadStb,
  input  logic [LEN_CODE_W-1:0] lenCode,
  input  logic [DIV_CODE_W-1:0] divCode,
  input  logic                  slowSel,
  output ftxStrobe_t            strb,
  output logic                  frame,
  output logic                  busy,
  output logic                  sclk
);

  localparam int STEP  = WORD_W >> LEN_CODE_W;
  localparam int BIT_W = $clog2(WORD_W);
  localparam int PH_W  = 1 << DIV_CODE_W;

  ftxState_t             state;
  logic                  pending;
  logic [BIT_W-1:0]      bitCnt;
  logic [PH_W-1:0]       phase;
  logic [DIV_CODE_W-1:0] divQ;
  logic                  slowQ;

  logic [PH_W-1:0] phaseTop;
  logic [PH_W-1:0] halfMark;
  logic            periodLast;
  logic            inShift;
  logic            launch;

  assign inShift    = (state == ST_SHIFT);
  assign phaseTop   = PH_W'((2 << int'(divQ)) - 1);
  assign halfMark   = PH_W'(1 << int'(divQ));
  assign periodLast = slowQ ? (phase == phaseTop) : 1'b1;

  always_comb begin
    strb.launchHeld  = !inShift && pending;
    strb.launchNew   = !inShift && !pending && loadStb;
    strb.captureHold = inShift && loadStb && !pending;
    strb.shiftNext   = inShift && periodLast && (bitCnt != '0);
  end

  assign launch = strb.launchHeld || strb.launchNew;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      phase  <= '0;
      divQ   <= '0;
      slowQ  <= 1'b0;
    end else if (launch) begin
      state  <= ST_SHIFT;
      bitCnt <= BIT_W'((int'(lenCode) + 1) * STEP - 1);
      phase  <= '0;
      divQ   <= divCode;
      slowQ  <= slowSel;
    end else if (inShift) begin
      if (periodLast) begin
        phase <= '0;
        if (bitCnt == '0) state <= ST_IDLE;
        else              bitCnt <= bitCnt - 1'b1;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 pending <= 1'b0;
    else if (strb.launchHeld)  pending <= 1'b0;
    else if (strb.captureHold) pending <= 1'b1;
  end

  assign frame = inShift;
  assign busy  = inShift || pending;
  // Divided mode: second half of each bit is high. Master mode: the
  // inverted master clock, so data (changed at clk rise) moves on its fall.
  assign sclk  = inShift && (slowQ ? (phase >= halfMark) : ~clk);

endmodule

// File: rtl/ftx_datapath.sv
module ftx_datapath
  import ftx_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ftxStrobe_t        strb,
  input  logic [WORD_W-1:0] wordIn,
  output logic              serData
);

  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] holdReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                shiftReg <= '0;
    else if (strb.launchNew)  shiftReg <= wordIn;
    else if (strb.launchHeld) shiftReg <= holdReg;
    else if (strb.shiftNext)  shiftReg <= {shiftReg[WORD_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 holdReg <= '0;
    else if (strb.captureHold) holdReg <= wordIn;
  end

  assign serData = shiftReg[WORD_W-1];

endmodule

// File: rtl/freq_serial_tx.sv
module freq_serial_tx
  import ftx_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int LEN_CODE_W = 2,
  parameter int DIV_CODE_W = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  loadStb,
  input  logic [WORD_W-1:0]     wordIn,
  input  logic [LEN_CODE_W-1:0] lenCode,
  input  logic [DIV_CODE_W-1:0] divCode,
  input  logic                  slowSel,
  output logic                  serData,
  output logic                  serClk,
  output logic                  serFrame,
  output logic                  busy
);

  ftxStrobe_t strb;

  ftx_ctrl #(
    .WORD_W(WORD_W), .LEN_CODE_W(LEN_CODE_W), .DIV_CODE_W(DIV_CODE_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .loadStb(loadStb), .lenCode(lenCode),
    .divCode(divCode), .slowSel(slowSel), .strb(strb),
    .frame(serFrame), .busy(busy), .sclk(serClk)
  );

  ftx_datapath #(.WORD_W(WORD_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wordIn(wordIn), .serData(serData)
  );

endmodule

// File: rtl/ftx_checker.sv
module ftx_checker #(
  parameter int WORD_W     = 32,
  parameter int DIV_CODE_W = 2
) (
  input logic clk,
  input logic rstN,
  input logic loadStb,
  input logic busy,
  input logic serFrame,
  input logic serClk,
  input logic serData
);

  localparam int MAX_FRAME = WORD_W * (2 << ((1 << DIV_CODE_W) - 1));
  localparam int CNT_W     = $clog2(MAX_FRAME + 2);

  logic [CNT_W-1:0] frameCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         frameCnt <= '0;
    else if (serFrame) frameCnt <= frameCnt + 1'b1;
    else               frameCnt <= '0;
  end

  // R7
  busy_cover_chk: assert property (@(posedge clk) disable iff (!rstN)
    serFrame |-> busy);

  // R7
  held_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && serFrame) |=> busy);

  // R2
  launch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && !busy) |=> serFrame);

  // R2
  frame_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameCnt <= CNT_W'(MAX_FRAME));

  // R6
  data_hold_chk: assert property (@(negedge clk) disable iff (!rstN)
    (serClk && $past(serClk)) |-> $stable(serData));

  // R6
  idle_clk_chk: assert property (@(negedge clk) disable iff (!rstN)
    !serFrame |-> !serClk);

endmodule

bind freq_serial_tx ftx_checker #(.WORD_W(WORD_W), .DIV_CODE_W(DIV_CODE_W)) chk_i (
  .clk(clk), .rstN(rstN), .loadStb(loadStb), .busy(busy),
  .serFrame(serFrame), .serClk(serClk), .serData(serData)
);

// File: tb/freq_serial_tx_tb_top.sv
module freq_serial_tx_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        loadStb;
  logic [31:0] wordIn;
  logic [1:0]  lenCode;
  logic [1:0]  divCode;
  logic        slowSel;
  logic        serData, serClk, serFrame, busy;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  freq_serial_tx dut_i (
    .clk(clk), .rstN(rstN), .loadStb(loadStb), .wordIn(wordIn),
    .lenCode(lenCode), .divCode(divCode), .slowSel(slowSel),
    .serData(serData), .serClk(serClk), .serFrame(serFrame), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive a load at a negedge; return at the negedge after the launch edge
  task automatic startLoad(input logic [31:0] w, input logic [1:0] len,
                           input logic [1:0] dv, input logic slow);
    wordIn = w; lenCode = len; divCode = dv; slowSel = slow; loadStb = 1'b1;
    @(negedge clk);
    loadStb = 1'b0;
  endtask

  // Check one frame cycle by cycle; optional mid-frame loads / config flips
  task automatic runFrame(input logic [31:0] w, input int nBits, input int per,
                          input bit slow, input string req,
                          input int injA, input logic [31:0] wA,
                          input int injB, input logic [31:0] wB,
                          input int chgAt);
    bit   bad;
    int   bitIdx;
    logic expD, expC;
    bad = 1'b0;
    for (int j = 0; j < nBits * per; j++) begin
      bitIdx = j / per;
      expD   = w[31 - bitIdx];
      expC   = ((j % per) >= (per / 2));
      if (!bad && (serFrame !== 1'b1 || busy !== 1'b1 || serData !== expD ||
                   (slow && serClk !== expC))) begin
        bad = 1'b1;
        $display("FAIL %s cycle %0d: frame=%b busy=%b data=%b clk=%b expected frame=1 busy=1 data=%b clk=%b",
                 req, j, serFrame, busy, serData, serClk, expD, slow ? expC : serClk);
      end
      if (j == injA)      begin loadStb = 1'b1; wordIn = wA; end
      else if (j == injB) begin loadStb = 1'b1; wordIn = wB; end
      else                loadStb = 1'b0;
      if (j == chgAt) begin lenCode = ~lenCode; divCode = ~divCode; end
      @(negedge clk);
    end
    loadStb = 1'b0;
    nChecks++;
    if (bad) nFails++;
  endtask

  task automatic endCheck(input bit expBusy, input string req);
    check(serFrame == 1'b0, req, "frame after word", int'(serFrame), 0);
    check(busy == expBusy, req, "busy after word", int'(busy), int'(expBusy));
  endtask

  task automatic t_reset();
    // R1
    check(serFrame == 0 && busy == 0 && serClk == 0 && serData == 0, "R1",
          "reset outputs {frame,busy,clk,data}",
          int'({serFrame, busy, serClk, serData}), 0);
  endtask

  task automatic t_fast32();
    // R3 R4: full word, one bit per cycle
    startLoad(32'hA5C3_96E1, 2'd3, 2'd0, 1'b0);
    runFrame(32'hA5C3_96E1, 32, 1, 1'b0, "R4", -1, '0, -1, '0, -1);
    endCheck(1'b0, "R2");
  endtask

  task automatic t_lengths();
    // R3: truncated words keep upper bits
    for (int c = 0; c < 3; c++) begin
      startLoad(32'h1234_5678 ^ (32'h0F0F_F0F0 << c), 2'(c), 2'd0, 1'b0);
      runFrame(32'h1234_5678 ^ (32'h0F0F_F0F0 << c), 8 * (c + 1), 1, 1'b0,
               "R3", -1, '0, -1, '0, -1);
      endCheck(1'b0, "R3");
    end
  endtask

  task automatic t_slow();
    // R5 R6: divided clock for every ratio
    for (int d = 0; d < 4; d++) begin
      startLoad(32'hC69A_0000 + 32'(d << 24), 2'd0, 2'(d), 1'b1);
      runFrame(32'hC69A_0000 + 32'(d << 24), 8, 2 << d, 1'b1, "R5",
               -1, '0, -1, '0, -1);
      endCheck(1'b0, "R6");
    end
  endtask

  task automatic t_held();
    // R7 held load, R8 third load dropped
    startLoad(32'hF00F_0000, 2'd0, 2'd0, 1'b0);
    runFrame(32'hF00F_0000, 8, 1, 1'b0, "R7", 2, 32'h5A00_0000, 5, 32'hFF00_0000, -1);
    endCheck(1'b1, "R7");
    @(negedge clk);
    runFrame(32'h5A00_0000, 8, 1, 1'b0, "R7", -1, '0, -1, '0, -1);
    endCheck(1'b0, "R8");
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(serFrame == 1'b0, "R8", "no frame for dropped load", int'(serFrame), 0);
    end
  endtask

  task automatic t_cfgLatch();
    // R9: config flips mid-frame are ignored
    startLoad(32'h9D3B_7E11, 2'd1, 2'd1, 1'b1);
    runFrame(32'h9D3B_7E11, 16, 4, 1'b1, "R9", -1, '0, -1, '0, 3);
    endCheck(1'b0, "R9");
  endtask

  initial begin
    rstN = 1'b0; loadStb = 1'b0; wordIn = '0; lenCode = '0; divCode = '0; slowSel = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_fast32();
    t_lengths();
    t_slow();
    t_held();
    t_cfgLatch();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule